// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the fixed bus sequence that sits between a CPU accepting an interrupt and the CPU fetching the first instruction of the handler. It serves a small core with an 8-bit data bus and a 20-bit address space. A hardware request is taken at an instruction boundary. It is also taken in the middle of a suspendable instruction, meaning the string-move and multiply-accumulate kind. A software trap is taken when its instruction completes. Once a request is taken, the block owns the bus for exactly 20 cycles.

During those cycles the block reads an information byte that identifies the hardware source and its level, and it pulses a clear back to that source. It pushes the pre-entry flags and the 20-bit PC as four bytes below the stack pointer, in a fixed scrambled order. It then reads a three-byte handler address from the vector table. On the last cycle it presents the new PC, the new flag word and the new stack pointer, together with a one-cycle done pulse. The core then continues from there. Requests that arrive while the sequence is running are not taken until it ends.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware request (hw_req) is accepted only when flag bit 6 (interrupt enable) of flg_in is 1 and either instr_done or susp_ok is 1. A software request (sw_req) is accepted when instr_done is 1, whatever bit 6 is, and it takes precedence. In both cases busy is 1 in the following cycle, which is sequence cycle 0.
- R2: For a hardware entry, cycle 0 is a read (rd=1) of address 0x00000. The byte returned carries the level in bits 7:5 and the source number in bits 4:0. In cycle 1, clr is 1 and clr_num holds that number. A software entry performs no access in cycle 0 and never raises clr.
- R3: The block writes the stack in cycles 4, 6, 8 and 10, at SP-2, SP-1, SP-4 and SP-3 in that order, where SP is sp_in at acceptance. The bytes written are:
  - SP-2: flags[7:0]
  - SP-1: {flags[15:12], PC[19:16]}
  - SP-4: PC[7:0]
  - SP-3: PC[15:8]
- R4: The flags output at done is the accepted flg_in with bit 6 (interrupt enable) and bit 3 (single-step enable) cleared. Bit 7 (stack select) is cleared as well, except for a software entry numbered 32 to 63, where it keeps its value. All other bits outside 14:12 are unchanged.
- R5: Flag bits 14:12 (priority level) at done hold the level from the information byte for a hardware entry, and are unchanged for a software entry.
- R6: In cycles 12, 14 and 16 the block reads VEC, VEC+1 and VEC+2, where VEC = VEC_BASE + 4 x number. At done, pc_out = {byte2[3:0], byte1, byte0}.
- R7: done is 1 only in sequence cycle 19, and busy is 0 in the cycle after done. At done, sp_out = SP - 4, taken modulo 2^20.
- R8: Requests and changes on flg_in, pc_in and sp_in during a sequence have no effect on it. A request still held when the sequence ends is accepted one idle cycle after done.
- R9: After reset, busy, rd, wr, clr and done are 0.
- R10: rd and wr are never 1 together, and they are 1 only in the cycles named in R2, R3 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 1 | Hardware interrupt pending |
| susp_ok | input | 1 | Current instruction may be suspended |
| instr_done | input | 1 | Instruction boundary strobe |
| sw_req | input | 1 | Software trap at this boundary |
| sw_num | input | 6 | Software trap number |
| flg_in | input | 16 | Current flag word |
| pc_in | input | 20 | PC to resume at |
| sp_in | input | 20 | Current stack pointer |
| rdata | input | 8 | Read data bus |
| addr | output | 20 | Address bus |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| wdata | output | 8 | Write data bus |
| busy | output | 1 | Sequence in progress |
| clr | output | 1 | Clear the pending bit of the accepted source |
| clr_num | output | 5 | Source whose pending bit is cleared |
| done | output | 1 | New PC, flags and SP valid |
| pc_out | output | 20 | Handler start address |
| flg_out | output | 16 | Flag word for the handler |
| sp_out | output | 20 | Stack pointer after the pushes |

## Verification
The assertions assume that reset is applied before the first request, and that sp_in is steady in the cycle in which a request is accepted, because the reference stack pointer is sampled there. They also rely on the read bus being sampled only at the edge that ends a read cycle. The stimulus meets these assumptions: it sets flg_in, pc_in and sp_in together with the request at a falling edge, and it drives rdata at the falling edge of each expected read cycle. It disturbs all inputs only after a sequence is already running.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   // flag word layout
   localparam int FLG_W    = 16;
   localparam int BIT_IE   = 6;
   localparam int BIT_SS   = 3;
   localparam int BIT_STK  = 7;
   localparam int LVL_LO   = 12;
   localparam int LVL_W    = 3;
   localparam int HWNUM_W  = 5;
   localparam int NUM_W    = 6;
   // sequence schedule (cycle index within the sequence)
   localparam int SEQ_LEN  = 20;
   localparam int P_INFO   = 0;
   localparam int P_PUSH0  = 4;
   localparam int P_PUSH1  = 6;
   localparam int P_PUSH2  = 8;
   localparam int P_PUSH3  = 10;
   localparam int P_VEC0   = 12;
   localparam int P_VEC1   = 14;
   localparam int P_VEC2   = 16;

   function automatic logic [FLG_W-1:0] entry_flags(
      input logic [FLG_W-1:0] f,
      input logic             is_sw,
      input logic [NUM_W-1:0] num,
      input logic [LVL_W-1:0] lvl);
      logic [FLG_W-1:0] r;
      r = f;
      r[BIT_IE] = 1'b0;
      r[BIT_SS] = 1'b0;
      if (!(is_sw && num[NUM_W-1])) r[BIT_STK] = 1'b0;
      r[LVL_LO +: LVL_W] = lvl;
      return r;
   endfunction
endpackage

// File: rtl/entry_step_ctr.sv
module entry_step_ctr #(
   parameter int SEQ_LEN = 20,
   localparam int CW = $clog2(SEQ_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [CW-1:0] cnt,
   output logic          last
);
   assign last = busy && (cnt == CW'(SEQ_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/entry_bus_plan.sv
module entry_bus_plan
   import irq_entry_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CW     = 5
) (
   input  logic              busy,
   input  logic [CW-1:0]     cnt,
   input  logic              info_en,
   input  logic [ADDR_W-1:0] sp,
   input  logic [ADDR_W-1:0] vec,
   input  logic [FLG_W-1:0]  flg,
   input  logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] addr,
   output logic              rd,
   output logic              wr,
   output logic [7:0]        wdata
);
   always_comb begin
      rd    = 1'b0;
      wr    = 1'b0;
      addr  = '0;
      wdata = '0;
      if (busy) begin
         case (int'(cnt))
            P_INFO:  rd = info_en;
            P_PUSH0: begin wr = 1'b1; addr = sp - ADDR_W'(2); wdata = flg[7:0]; end
            P_PUSH1: begin wr = 1'b1; addr = sp - ADDR_W'(1); wdata = {flg[15:12], pc[19:16]}; end
            P_PUSH2: begin wr = 1'b1; addr = sp - ADDR_W'(4); wdata = pc[7:0]; end
            P_PUSH3: begin wr = 1'b1; addr = sp - ADDR_W'(3); wdata = pc[15:8]; end
            P_VEC0:  begin rd = 1'b1; addr = vec; end
            P_VEC1:  begin rd = 1'b1; addr = vec + ADDR_W'(1); end
            P_VEC2:  begin rd = 1'b1; addr = vec + ADDR_W'(2); end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/entry_vec_gather.sv
module entry_vec_gather #(
   parameter int ADDR_W = 20,
   parameter int CW     = 5,
   parameter int FIRST  = 12,
   localparam int NB    = (ADDR_W + 7) / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic [CW-1:0]     cnt,
   input  logic [7:0]        rdata,
   output logic [ADDR_W-1:0] pc
);
   for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam int W = (b == NB - 1) ? (ADDR_W - 8 * b) : 8;
      logic [W-1:0] part;
      always_ff @(posedge clk) begin
         if (!rst_n)                                    part <= '0;
         else if (busy && cnt == CW'(FIRST + 2 * b))    part <= rdata[W-1:0];
      end
      assign pc[8*b +: W] = part;
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int              ADDR_W   = 20,
   parameter logic [19:0]     VEC_BASE = 20'hFFD00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_req,
   input  logic              susp_ok,
   input  logic              instr_done,
   input  logic              sw_req,
   input  logic [5:0]        sw_num,
   input  logic [15:0]       flg_in,
   input  logic [19:0]       pc_in,
   input  logic [19:0]       sp_in,
   input  logic [7:0]        rdata,
   output logic [19:0]       addr,
   output logic              rd,
   output logic              wr,
   output logic [7:0]        wdata,
   output logic              busy,
   output logic              clr,
   output logic [4:0]        clr_num,
   output logic              done,
   output logic [19:0]       pc_out,
   output logic [15:0]       flg_out,
   output logic [19:0]       sp_out
);
   localparam int CW = $clog2(SEQ_LEN);

   if (ADDR_W != 20) begin : g_bad_addr
      $error("irq_entry_seq: stack frame layout needs ADDR_W of 20");
   end
   if (VEC_BASE[1:0] != 2'b00) begin : g_bad_base
      $error("irq_entry_seq: VEC_BASE must be 4-byte aligned");
   end
   if (HWNUM_W + LVL_W != 8) begin : g_bad_info
      $error("irq_entry_seq: information byte must hold level and number");
   end

   logic              take_sw, take_hw, start;
   logic [CW-1:0]     cnt;
   logic              is_sw_q;
   logic [NUM_W-1:0]  num_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [FLG_W-1:0]  flg_q;
   logic [19:0]       pc_q, sp_q, vec;

   assign take_sw = sw_req && instr_done;
   assign take_hw = !take_sw && hw_req && flg_in[BIT_IE] && (instr_done || susp_ok);
   assign start   = !busy && (take_sw || take_hw);

   entry_step_ctr #(.SEQ_LEN(SEQ_LEN)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .cnt(cnt), .last(done));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_sw_q <= 1'b0;
         num_q   <= '0;
         lvl_q   <= '0;
         flg_q   <= '0;
         pc_q    <= '0;
         sp_q    <= '0;
         clr     <= 1'b0;
      end else begin
         clr <= busy && (cnt == CW'(P_INFO)) && !is_sw_q;
         if (start) begin
            is_sw_q <= take_sw;
            num_q   <= take_sw ? sw_num : '0;
            lvl_q   <= flg_in[LVL_LO +: LVL_W];
            flg_q   <= flg_in;
            pc_q    <= pc_in;
            sp_q    <= sp_in;
         end else if (busy && cnt == CW'(P_INFO) && !is_sw_q) begin
            num_q <= {1'b0, rdata[HWNUM_W-1:0]};
            lvl_q <= rdata[7 -: LVL_W];
         end
      end
   end

   assign vec     = VEC_BASE + {12'd0, num_q, 2'b00};
   assign clr_num = num_q[HWNUM_W-1:0];

   entry_bus_plan #(.ADDR_W(20), .CW(CW)) u_bus (
      .busy(busy), .cnt(cnt), .info_en(!is_sw_q),
      .sp(sp_q), .vec(vec), .flg(flg_q), .pc(pc_q),
      .addr(addr), .rd(rd), .wr(wr), .wdata(wdata));

   entry_vec_gather #(.ADDR_W(20), .CW(CW), .FIRST(P_VEC0)) u_gather (
      .clk(clk), .rst_n(rst_n), .busy(busy), .cnt(cnt),
      .rdata(rdata), .pc(pc_out));

   assign flg_out = entry_flags(flg_q, is_sw_q, num_q, lvl_q);
   assign sp_out  = sp_q - 20'd4;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rd,
   input logic        wr,
   input logic        busy,
   input logic        done,
   input logic        clr,
   input logic [19:0] addr,
   input logic [19:0] sp_in,
   input logic [19:0] sp_out,
   input logic [15:0] flg_out
);
   logic [4:0]  len;
   logic        busy_d;
   logic [19:0] sp_d, sp_ref;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len    <= '0;
         busy_d <= 1'b0;
         sp_d   <= '0;
         sp_ref <= '0;
      end else begin
         len    <= busy ? len + 1'b1 : '0;
         busy_d <= busy;
         sp_d   <= sp_in;
         if (busy && !busy_d) sp_ref <= sp_d;
      end
   end

   a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n) !(rd && wr));
   a_r10_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n) (rd || wr) |-> busy);
   a_r7_done_len: assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy && len == 5'd19));
   a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
   a_r8_no_early_end: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);
   a_r7_sp_drop: assert property (@(posedge clk) disable iff (!rst_n) done |-> sp_out == sp_ref - 20'd4);
   a_r4_ie_ss_clear: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!flg_out[6] && !flg_out[3]));
   a_r2_clr_after_info: assert property (@(posedge clk) disable iff (!rst_n) clr |-> ($past(rd) && $past(addr) == 20'd0));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .busy(busy), .done(done),
   .clr(clr), .addr(addr), .sp_in(sp_in), .sp_out(sp_out), .flg_out(flg_out));

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
   localparam logic [19:0] VB = 20'hFFD00;

   typedef struct packed {
      logic        sw;
      logic        susp;
      logic [5:0]  num;
      logic [2:0]  lvl;
      logic [15:0] flg;
      logic [19:0] pc;
      logic [19:0] sp;
   } case_t;

   localparam int NCASE = 7;
   localparam case_t CASES [NCASE] = '{
      '{1'b0, 1'b0, 6'd5,  3'd3, 16'h20C9, 20'h12345, 20'h00800},
      '{1'b0, 1'b1, 6'd31, 3'd7, 16'h7048, 20'hABCDE, 20'h00403},
      '{1'b1, 1'b0, 6'd40, 3'd0, 16'h50C8, 20'h00010, 20'h00004},
      '{1'b1, 1'b0, 6'd12, 3'd0, 16'h30C0, 20'hFFFFF, 20'h00002},
      '{1'b1, 1'b0, 6'd63, 3'd0, 16'h0088, 20'h5A5A5, 20'h10000},
      '{1'b1, 1'b0, 6'd32, 3'd0, 16'h6000, 20'h0F0F0, 20'h00FFF},
      '{1'b0, 1'b0, 6'd0,  3'd0, 16'h00C8, 20'h00001, 20'h03000}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic hw_req = 0, susp_ok = 0, instr_done = 0, sw_req = 0;
   logic [5:0]  sw_num = '0;
   logic [15:0] flg_in = '0;
   logic [19:0] pc_in = '0, sp_in = '0;
   logic [7:0]  rdata = '0;
   logic [19:0] addr, pc_out, sp_out;
   logic        rd, wr, busy, clr, done;
   logic [7:0]  wdata;
   logic [4:0]  clr_num;
   logic [15:0] flg_out;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   irq_entry_seq #(.ADDR_W(20), .VEC_BASE(VB)) u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .susp_ok(susp_ok),
      .instr_done(instr_done), .sw_req(sw_req), .sw_num(sw_num),
      .flg_in(flg_in), .pc_in(pc_in), .sp_in(sp_in), .rdata(rdata),
      .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .busy(busy),
      .clr(clr), .clr_num(clr_num), .done(done), .pc_out(pc_out),
      .flg_out(flg_out), .sp_out(sp_out));

   function automatic logic [7:0] vbyte(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      hw_req = 0; susp_ok = 0; instr_done = 0; sw_req = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_case(input case_t c, input bit noise);
      logic        hw;
      logic [19:0] vec, epc;
      logic [15:0] eflg;
      hw   = !c.sw;
      vec  = VB + {12'd0, c.num, 2'b00};
      epc  = {vbyte(vec + 20'd2), vbyte(vec + 20'd1), vbyte(vec)};
      eflg = c.flg;
      eflg[6] = 1'b0;
      eflg[3] = 1'b0;
      if (!(c.sw && c.num >= 6'd32)) eflg[7] = 1'b0;
      if (hw) eflg[14:12] = c.lvl;

      @(negedge clk);
      flg_in = c.flg; pc_in = c.pc; sp_in = c.sp;
      if (c.sw) begin
         sw_req = 1; sw_num = c.num; instr_done = 1;
      end else begin
         hw_req = 1;
         if (c.susp) susp_ok = 1; else instr_done = 1;
      end
      @(posedge clk); @(negedge clk);
      chk("R1 request accepted", {31'd0, busy}, 32'd1);
      sw_req = 0; instr_done = 0; susp_ok = 0;

      for (int k = 0; k < 20; k++) begin
         logic        er, ew;
         logic [19:0] ea;
         logic [7:0]  ed;
         er = 0; ew = 0; ea = '0; ed = '0;
         case (k)
            0:  if (hw) begin er = 1; ea = 20'd0; end
            4:  begin ew = 1; ea = c.sp - 20'd2; ed = c.flg[7:0]; end
            6:  begin ew = 1; ea = c.sp - 20'd1; ed = {c.flg[15:12], c.pc[19:16]}; end
            8:  begin ew = 1; ea = c.sp - 20'd4; ed = c.pc[7:0]; end
            10: begin ew = 1; ea = c.sp - 20'd3; ed = c.pc[15:8]; end
            12: begin er = 1; ea = vec; end
            14: begin er = 1; ea = vec + 20'd1; end
            16: begin er = 1; ea = vec + 20'd2; end
            default: ;
         endcase
         rdata = (k == 0) ? {c.lvl, c.num[4:0]} : vbyte(ea);

         chk("R10 strobes rd/wr", {30'd0, rd, wr}, {30'd0, er, ew});
         if (er || ew) begin
            if (k == 0)      chk("R2 info read address", {12'd0, addr}, {12'd0, ea});
            else if (k < 12) chk("R3 stack write address", {12'd0, addr}, {12'd0, ea});
            else             chk("R6 vector read address", {12'd0, addr}, {12'd0, ea});
         end
         if (ew) chk("R3 stack write data", {24'd0, wdata}, {24'd0, ed});
         if (k == 1) begin
            if (hw) chk("R2 source clear", {26'd0, clr, clr_num}, {26'd0, 1'b1, c.num[4:0]});
            else    chk("R2 no clear on software entry", {31'd0, clr}, 32'd0);
         end
         chk("R7 done timing", {31'd0, done}, {31'd0, k == 19});
         if (k == 19) begin
            chk("R4 flag bits 7/6/3", {29'd0, flg_out[7], flg_out[6], flg_out[3]},
                {29'd0, eflg[7], eflg[6], eflg[3]});
            chk("R4 whole flag word", {16'd0, flg_out}, {16'd0, eflg});
            chk("R5 priority level", {29'd0, flg_out[14:12]}, {29'd0, eflg[14:12]});
            chk("R6 handler PC", {12'd0, pc_out}, {12'd0, epc});
            chk("R7 stack pointer", {12'd0, sp_out}, {12'd0, c.sp - 20'd4});
         end
         if (hw && k == 1 && !noise) hw_req = 0;
         if (noise && k == 2) begin
            sw_req = 1; instr_done = 1; sw_num = 6'd9;
            flg_in = 16'h0040; pc_in = 20'h77777; sp_in = 20'h55555;
         end
         @(posedge clk); @(negedge clk);
      end
      if (!noise) chk("R7 idle after done", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run hung actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R9: reset state
      chk("R9 reset busy/rd/wr/clr/done", {27'd0, busy, rd, wr, clr, done}, 32'd0);

      // table walk
      for (int i = 0; i < NCASE; i++) begin
         run_case(CASES[i], 1'b0);
         repeat (2) @(negedge clk);
      end

      // R8: disturbance during a sequence, then a held request
      run_case(CASES[0], 1'b1);
      chk("R8 idle cycle after done", {31'd0, busy}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R8 held request taken after completion", {31'd0, busy}, 32'd1);
      hw_req = 0; sw_req = 0; instr_done = 0;
      do_reset();

      // R1: interrupt enable clear blocks a hardware request
      @(negedge clk);
      flg_in = 16'h0000; hw_req = 1; instr_done = 1;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R1 blocked by enable bit 6 clear", {31'd0, busy}, 32'd0);
      end
      // R1: no boundary and not suspendable
      flg_in = 16'h0040; instr_done = 0; susp_ok = 0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R1 held off between boundaries", {27'd0, busy, rd, wr, clr, done}, 32'd0);
      end
      hw_req = 0;

      // R1: software request precedes hardware at the same boundary
      @(negedge clk);
      flg_in = 16'h0040; pc_in = 20'h00100; sp_in = 20'h00200;
      hw_req = 1; sw_req = 1; sw_num = 6'd33; instr_done = 1;
      @(posedge clk); @(negedge clk);
      hw_req = 0; sw_req = 0; instr_done = 0;
      chk("R1 software first: no info read", {30'd0, busy, rd}, {30'd0, 1'b1, 1'b0});

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule